// File: doc/BRIEF.md
# Channel Interrupt Status Aggregator

This block gathers interrupt events from 64 physical channels and keeps one pending flag per channel. The flags are organised as two 32-bit status words: word 0 covers channels 0 to 31 and word 1 covers channels 32 to 63. Each channel has two single-cycle inputs, a done pulse and an error pulse. Either pulse sets that channel's flag. Two level-sensitive interrupt lines tell a host controller that a group has work pending.

The host uses a small synchronous register port. A strobe with a 2-bit address reads a status word or the control register. Read data appears one cycle after the strobe. The control register selects one of two clear policies. In clear-on-read mode, a read clears the bits it returned. In write-one-to-clear mode, the host writes ones to the bits it wants cleared. The control register also selects the interrupt routing: either one line per group, or both groups merged onto line 0.

The control logic holds two small state machines. The clear-policy machine has the states `CM_CLEAR_ON_READ` and `CM_WRITE_ONE_CLEAR`. A control write with bit 0 = 1 moves it to `CM_WRITE_ONE_CLEAR`, and a control write with bit 0 = 0 moves it to `CM_CLEAR_ON_READ`. The routing machine has the states `RT_SPLIT` and `RT_MERGED`. A control write moves it by bit 1: 1 selects merged and 0 selects split. Any other access leaves both machines where they are. Each host cycle is decoded into one access kind: `ACC_IDLE`, `ACC_READ` or `ACC_WRITE`.

Top module: `chint_aggregator`

## Requirements
- R1: After reset, both status words, the control register, `host_rdata` and both interrupt lines are 0.
- R2: A done or error pulse on channel c sets bit (c mod 32) of status word c/32 at the next clock edge. Without such a pulse, no bit becomes set.
- R3: With control bit 1 = 0, `irq_out[0]` is high exactly while word 0 is non-zero, and `irq_out[1]` is high exactly while word 1 is non-zero.
- R4: With control bit 1 = 1, `irq_out[0]` is high while either word is non-zero, and `irq_out[1]` is held low.
- R5: In clear-on-read mode (control bit 0 = 0), a read of address 0 or 1 returns that word on `host_rdata` one cycle later. Only the bits returned as 1 are cleared, and only in the word that was read.
- R6: A channel event in the same cycle as a read-clear or a write-clear of its bit leaves the bit set.
- R7: In write-one-to-clear mode (control bit 0 = 1), reads do not clear. A write to address 0 or 1 clears the bits where the write data is 1 and leaves the bits where it is 0.
- R8: In clear-on-read mode, writes to addresses 0 and 1 change no status bit.
- R9: Address 2 is the control register. A write stores bits 1:0 (bit 0 clear policy, bit 1 routing). A read returns them with bits 31:2 as 0.
- R10: A read of address 3 returns 0, and a write to address 3 changes neither the control register nor any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_done | input | 64 | Per-channel done pulse, bit c = channel c |
| chan_err | input | 64 | Per-channel error pulse, bit c = channel c |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read, qualified by `host_sel` |
| host_addr | input | 2 | 0 = word 0, 1 = word 1, 2 = control, 3 = unused |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| irq_out | output | 2 | Level interrupt lines to the host |

## Verification
The hardest case to reach is a channel event landing in the very cycle that clears its own bit. The clear can come from a clear-on-read access or from a write-one-to-clear write. In either case, the set must win. The stimulus table puts an event pulse and a host access in the same row, so both reach the same edge. The following rows then read or observe the interrupt lines to show that the bit survived.

// File: rtl/chint_pkg.sv
package chint_pkg;

    // Clear policy state: value equals control bit 0.
    typedef enum logic {
        CM_CLEAR_ON_READ   = 1'b0,
        CM_WRITE_ONE_CLEAR = 1'b1
    } clr_mode_e;

    // Interrupt routing state: value equals control bit 1.
    typedef enum logic {
        RT_SPLIT  = 1'b0,
        RT_MERGED = 1'b1
    } route_e;

    // Decoded host access kind for one cycle.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } access_e;

endpackage

// File: rtl/chint_status_word.sv
module chint_status_word #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] done_i,
    input  logic [WORD_W-1:0] err_i,
    input  logic              rd_clr_i,
    input  logic              wr_clr_i,
    input  logic [WORD_W-1:0] wr_mask_i,
    output logic [WORD_W-1:0] word_o,
    output logic              any_o
);

    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] evt;
    logic [WORD_W-1:0] clr_mask;
    logic [WORD_W-1:0] word_d;

    // One event bit per channel.
    genvar b;
    generate
        for (b = 0; b < WORD_W; b++) begin : g_evt
            assign evt[b] = done_i[b] | err_i[b];
        end
    endgenerate

    always_comb begin
        clr_mask = '0;
        if (rd_clr_i) begin
            // A read clears exactly the bits it returns: the current contents.
            clr_mask = clr_mask | word_q;
        end
        if (wr_clr_i) begin
            clr_mask = clr_mask | wr_mask_i;
        end
        // Set has priority over clear.
        word_d = (word_q & ~clr_mask) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign word_o = word_q;
    assign any_o  = |word_q;

    // An event in cycle t is visible in the word at t+1, whatever clear came with it.
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((word_q & $past(evt)) == $past(evt)));

    // Without a clear request, no pending bit may drop.
    assert_no_spurious_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr_i && !wr_clr_i) |=> (($past(word_q) & ~word_q) == '0));

    // Without an event, no bit may rise.
    assert_no_spontaneous_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == '0) |=> ((word_q & ~$past(word_q)) == '0));

endmodule

// File: rtl/chint_host_port.sv
module chint_host_port
    import chint_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int NUM_GROUPS = 2,
    parameter int ADDR_W     = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             sel_i,
    input  logic                             wr_i,
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic [WORD_W-1:0]                wdata_i,
    input  logic [NUM_GROUPS-1:0][WORD_W-1:0] words_i,
    output logic [WORD_W-1:0]                rdata_o,
    output logic [NUM_GROUPS-1:0]            rd_clr_o,
    output logic [NUM_GROUPS-1:0]            wr_clr_o,
    output clr_mode_e                        mode_o,
    output route_e                           route_o
);

    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_GROUPS);

    access_e   acc;
    clr_mode_e mode_q, mode_d;
    route_e    route_q, route_d;
    logic      ctl_wr;
    logic [WORD_W-1:0] rd_mux;
    logic [WORD_W-1:0] rdata_q;
    logic [NUM_GROUPS-1:0] addr_hit;

    always_comb begin
        if (!sel_i) begin
            acc = ACC_IDLE;
        end else if (wr_i) begin
            acc = ACC_WRITE;
        end else begin
            acc = ACC_READ;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : g_hit
            assign addr_hit[g] = (addr_i == ADDR_W'(g));
        end
    endgenerate

    assign ctl_wr = (acc == ACC_WRITE) && (addr_i == CTL_ADDR);

    // Next-state logic for both control machines.
    always_comb begin
        mode_d  = mode_q;
        route_d = route_q;
        if (ctl_wr) begin
            unique case (mode_q)
                CM_CLEAR_ON_READ:   mode_d = wdata_i[0] ? CM_WRITE_ONE_CLEAR : CM_CLEAR_ON_READ;
                CM_WRITE_ONE_CLEAR: mode_d = wdata_i[0] ? CM_WRITE_ONE_CLEAR : CM_CLEAR_ON_READ;
                default:            mode_d = CM_CLEAR_ON_READ;
            endcase
            unique case (route_q)
                RT_SPLIT:  route_d = wdata_i[1] ? RT_MERGED : RT_SPLIT;
                RT_MERGED: route_d = wdata_i[1] ? RT_MERGED : RT_SPLIT;
                default:   route_d = RT_SPLIT;
            endcase
        end
    end

    // State registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= CM_CLEAR_ON_READ;
            route_q <= RT_SPLIT;
        end else begin
            mode_q  <= mode_d;
            route_q <= route_d;
        end
    end

    // Outputs: clear strobes and read selection.
    always_comb begin
        rd_clr_o = '0;
        wr_clr_o = '0;
        rd_mux   = '0;
        unique case (acc)
            ACC_IDLE: begin
            end
            ACC_READ: begin
                for (int k = 0; k < NUM_GROUPS; k++) begin
                    if (addr_hit[k]) begin
                        rd_mux = words_i[k];
                        rd_clr_o[k] = (mode_q == CM_CLEAR_ON_READ);
                    end
                end
                if (addr_i == CTL_ADDR) begin
                    rd_mux = {{(WORD_W-2){1'b0}}, route_q == RT_MERGED, mode_q == CM_WRITE_ONE_CLEAR};
                end
            end
            ACC_WRITE: begin
                for (int k = 0; k < NUM_GROUPS; k++) begin
                    wr_clr_o[k] = addr_hit[k] && (mode_q == CM_WRITE_ONE_CLEAR);
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (acc == ACC_READ) begin
            rdata_q <= rd_mux;
        end
    end

    assign rdata_o = rdata_q;
    assign mode_o  = mode_q;
    assign route_o = route_q;

    // Control state moves only on a control write.
    assert_ctl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> ($stable(mode_q) && $stable(route_q)));

    // Read data changes only after a read access.
    assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc != ACC_READ) |=> $stable(rdata_q));

endmodule

// File: rtl/chint_irq_combiner.sv
module chint_irq_combiner
    import chint_pkg::*;
#(
    parameter int NUM_GROUPS = 2
) (
    input  logic [NUM_GROUPS-1:0] pend_i,
    input  route_e                route_i,
    output logic [NUM_GROUPS-1:0] irq_o
);

    genvar g;
    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : g_line
            if (g == 0) begin : g_primary
                assign irq_o[g] = (route_i == RT_MERGED) ? (|pend_i) : pend_i[g];
            end else begin : g_secondary
                assign irq_o[g] = (route_i == RT_SPLIT) & pend_i[g];
            end
        end
    endgenerate

endmodule

// File: rtl/chint_aggregator.sv
module chint_aggregator
    import chint_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_done,
    input  logic [NUM_CH-1:0] chan_err,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic [NUM_CH/WORD_W-1:0] irq_out
);

    localparam int NUM_GROUPS = NUM_CH / WORD_W;

    logic [NUM_GROUPS-1:0][WORD_W-1:0] words;
    logic [NUM_GROUPS-1:0]             pend;
    logic [NUM_GROUPS-1:0]             rd_clr;
    logic [NUM_GROUPS-1:0]             wr_clr;
    clr_mode_e                         mode;
    route_e                            route;

    genvar g;
    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : g_word
            chint_status_word #(
                .WORD_W (WORD_W)
            ) u_word (
                .clk       (clk),
                .rst_n     (rst_n),
                .done_i    (chan_done[g*WORD_W +: WORD_W]),
                .err_i     (chan_err[g*WORD_W +: WORD_W]),
                .rd_clr_i  (rd_clr[g]),
                .wr_clr_i  (wr_clr[g]),
                .wr_mask_i (host_wdata),
                .word_o    (words[g]),
                .any_o     (pend[g])
            );
        end
    endgenerate

    chint_host_port #(
        .WORD_W     (WORD_W),
        .NUM_GROUPS (NUM_GROUPS),
        .ADDR_W     (ADDR_W)
    ) u_host (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (host_sel),
        .wr_i     (host_wr),
        .addr_i   (host_addr),
        .wdata_i  (host_wdata),
        .words_i  (words),
        .rdata_o  (host_rdata),
        .rd_clr_o (rd_clr),
        .wr_clr_o (wr_clr),
        .mode_o   (mode),
        .route_o  (route)
    );

    chint_irq_combiner #(
        .NUM_GROUPS (NUM_GROUPS)
    ) u_irq (
        .pend_i  (pend),
        .route_i (route),
        .irq_o   (irq_out)
    );

    // Merged routing keeps all lines above 0 low.
    assert_merged_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (route == RT_MERGED) |-> ((irq_out >> 1) == '0));

    // Write-one-to-clear mode never issues a read clear.
    assert_w1c_read_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_WRITE_ONE_CLEAR) |-> (rd_clr == '0));

    // Clear-on-read mode never issues a write clear.
    assert_cor_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_CLEAR_ON_READ) |-> (wr_clr == '0));

    // A merged line 0 is high whenever any group is pending.
    assert_merged_line0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((route == RT_MERGED) && (pend != '0)) |-> irq_out[0]);

endmodule

// File: tb/chint_aggregator_tb.sv
`timescale 1ns/1ps
module chint_aggregator_tb_top;

    localparam real HALF = 2.5;
    // Vector layout: op(2) addr(2) wdata(32) ev_v(1) ev_ch(6) ev_err(1) chk_rd(1) exp_rd(32) exp_irq(2)
    localparam int VW = 79;
    localparam int NV = 28;
    localparam logic [1:0] NOP = 2'd0, RD = 2'd1, WR = 2'd2;

    localparam logic [VW-1:0] VEC [NV] = '{
        // R2 R3: done on ch3, error on ch40
        {NOP, 2'd0, 32'h0, 1'b1, 6'd3,  1'b0, 1'b0, 32'h0, 2'b01},
        {NOP, 2'd0, 32'h0, 1'b1, 6'd40, 1'b1, 1'b0, 32'h0, 2'b11},
        // R5: read word 0 clears it only
        {RD,  2'd0, 32'h0, 1'b0, 6'd0,  1'b0, 1'b1, 32'h8, 2'b10},
        // R5: read word 1 while ch0 fires in word 0
        {RD,  2'd1, 32'h0, 1'b1, 6'd0,  1'b0, 1'b1, 32'h100, 2'b01},
        // R6: read word 0 with ch5 arriving the same cycle
        {RD,  2'd0, 32'h0, 1'b1, 6'd5,  1'b1, 1'b1, 32'h1, 2'b01},
        {RD,  2'd0, 32'h0, 1'b0, 6'd0,  1'b0, 1'b1, 32'h20, 2'b00},
        // R8: writes ignored in clear-on-read mode
        {NOP, 2'd0, 32'h0, 1'b1, 6'd7,  1'b0, 1'b0, 32'h0, 2'b01},
        {WR,  2'd0, 32'hFFFF_FFFF, 1'b0, 6'd0, 1'b0, 1'b0, 32'h0, 2'b01},
        {RD,  2'd0, 32'h0, 1'b0, 6'd0,  1'b0, 1'b1, 32'h80, 2'b00},
        // R9: select write-one-to-clear
        {WR,  2'd2, 32'h1, 1'b0, 6'd0,  1'b0, 1'b0, 32'h0, 2'b00},
        {RD,  2'd2, 32'h0, 1'b0, 6'd0,  1'b0, 1'b1, 32'h1, 2'b00},
        // R7: reads do not clear
        {NOP, 2'd0, 32'h0, 1'b1, 6'd33, 1'b0, 1'b0, 32'h0, 2'b10},
        {NOP, 2'd0, 32'h0, 1'b1, 6'd2,  1'b1, 1'b0, 32'h0, 2'b11},
        {RD,  2'd1, 32'h0, 1'b0, 6'd0,  1'b0, 1'b1, 32'h2, 2'b11},
        {RD,  2'd1, 32'h0, 1'b0, 6'd0,  1'b0, 1'b1, 32'h2, 2'b11},
        // R7: zero bits leave a bit alone
        {WR,  2'd1, 32'h1, 1'b0, 6'd0,  1'b0, 1'b0, 32'h0, 2'b11},
        // R6: write-clear and ch33 event together
        {WR,  2'd1, 32'h2, 1'b1, 6'd33, 1'b0, 1'b0, 32'h0, 2'b11},
        {WR,  2'd1, 32'h2, 1'b0, 6'd0,  1'b0, 1'b0, 32'h0, 2'b01},
        // R4: merge onto line 0
        {WR,  2'd2, 32'h3, 1'b0, 6'd0,  1'b0, 1'b0, 32'h0, 2'b01},
        {NOP, 2'd0, 32'h0, 1'b1, 6'd63, 1'b1, 1'b0, 32'h0, 2'b01},
        {WR,  2'd0, 32'h4, 1'b0, 6'd0,  1'b0, 1'b0, 32'h0, 2'b01},
        {RD,  2'd2, 32'h0, 1'b0, 6'd0,  1'b0, 1'b1, 32'h3, 2'b01},
        // R5 with merged routing
        {WR,  2'd2, 32'h2, 1'b0, 6'd0,  1'b0, 1'b0, 32'h0, 2'b01},
        {RD,  2'd1, 32'h0, 1'b0, 6'd0,  1'b0, 1'b1, 32'h8000_0000, 2'b00},
        // R10: unused address
        {WR,  2'd2, 32'h0, 1'b0, 6'd0,  1'b0, 1'b0, 32'h0, 2'b00},
        {RD,  2'd3, 32'h0, 1'b0, 6'd0,  1'b0, 1'b1, 32'h0, 2'b00},
        {WR,  2'd3, 32'hFFFF_FFFF, 1'b0, 6'd0, 1'b0, 1'b0, 32'h0, 2'b00},
        {RD,  2'd2, 32'h0, 1'b0, 6'd0,  1'b0, 1'b1, 32'h0, 2'b00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] chan_done = '0;
    logic [63:0] chan_err = '0;
    logic        host_sel = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [1:0]  irq_out;

    int n_chk = 0;
    int n_bad = 0;

    always #(HALF) clk = ~clk;

    chint_aggregator dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_done  (chan_done),
        .chan_err   (chan_err),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .irq_out    (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        chan_done  = '0;
        chan_err   = '0;
        host_sel   = 1'b0;
        host_wr    = 1'b0;
        host_addr  = '0;
        host_wdata = '0;
    endtask

    // Drive one cycle at the falling edge; results are sampled at the next falling edge.
    task automatic access(input logic [1:0] op, input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        idle_inputs();
        host_sel   = (op != NOP);
        host_wr    = (op == WR);
        host_addr  = a;
        host_wdata = d;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(2.0 * HALF * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [VW-1:0] v;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 irq in reset", {30'b0, irq_out}, 32'h0);
        check("R1 rdata in reset", host_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            @(negedge clk);
            idle_inputs();
            host_sel   = (v[78:77] != NOP);
            host_wr    = (v[78:77] == WR);
            host_addr  = v[76:75];
            host_wdata = v[74:43];
            if (v[42]) begin
                if (v[35]) chan_err[v[41:36]] = 1'b1;
                else       chan_done[v[41:36]] = 1'b1;
            end
            @(negedge clk);
            idle_inputs();
            check($sformatf("R3 irq row %0d", i), {30'b0, irq_out}, {30'b0, v[1:0]});
            if (v[34]) check($sformatf("R5 rdata row %0d", i), host_rdata, v[33:2]);
            // hold idle so each row is a single active cycle
        end

        // R2: word boundaries, ch31 and ch32, via done and error
        @(negedge clk);
        chan_done[31] = 1'b1;
        chan_err[32]  = 1'b1;
        @(negedge clk);
        idle_inputs();
        check("R2 boundary irq", {30'b0, irq_out}, 32'h3);
        access(RD, 2'd0, 32'h0);
        check("R2 ch31 in word0 bit31", host_rdata, 32'h8000_0000);
        access(RD, 2'd1, 32'h0);
        check("R2 ch32 in word1 bit0", host_rdata, 32'h1);
        check("R5 both words cleared", {30'b0, irq_out}, 32'h0);

        // R2: all channels at once
        @(negedge clk);
        chan_done = '1;
        @(negedge clk);
        idle_inputs();
        access(RD, 2'd1, 32'h0);
        check("R2 all ones word1", host_rdata, 32'hFFFF_FFFF);
        check("R5 word0 kept after word1 read", {30'b0, irq_out}, 32'h1);

        // R1: reset mid-run
        access(WR, 2'd2, 32'h3);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 irq after mid reset", {30'b0, irq_out}, 32'h0);
        check("R1 rdata after mid reset", host_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        access(RD, 2'd0, 32'h0);
        check("R1 word0 zero after reset", host_rdata, 32'h0);
        access(RD, 2'd2, 32'h0);
        check("R1 control zero after reset", host_rdata, 32'h0);

        finish_run();
    end

endmodule